// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block turns one reference clock into a square-wave serial clock running at sixteen times a chosen bit rate. It is meant to feed the receive and transmit timing of serial ports. A 4-bit select input picks one of thirteen fixed rates. Two select codes bypass the divider and send a user input straight to the output. That input can carry an outside frequency or a static level, which stops the serial clock entirely.

The block counts pulses of a reference that comes from one of two sources: a crystal-path clock or an external clock-pulse input. Both are sampled by the system clock, and each rising edge of the chosen source is one count. The active count pulse and the three stages of a divide-by-8 prescaler are exported, so external logic can derive clocks for more channels. When the external source is in use, the first high level on that input produces an initialization reset. A high level on it while the crystal path is selected holds the counters in reset.

Top module: `baud_gen`

## Requirements
- R1: With the reference at 2457600 counts per second, the output period in reference counts is round(2457600 / (16 × rate)) for rate_sel codes (binary) 0010=50, 0011=75, 0100=134.5, 0101=200, 0110=600, 0111=2400, 1000=9600, 1001=4800, 1010=1800, 1011=1200, 1100=2400, 1101=300, 1110=150, 1111=110 baud.
- R2: For every rate code except 1010, baud_out is high for exactly half of each period, starting at the period boundary.
- R3: Code 1010 (1800 baud) alternates periods of 85, 85 and 86 counts, so any three consecutive periods total 256 counts. High and low time within a period differ by at most one count.
- R4: With rate_sel 0000 or 0001 in effect, baud_out equals mux_in in the same cycle, whether mux_in is a static level or a toggling one. After system reset the in-effect code is 0000.
- R5: pre_q counts active reference pulses modulo 8 and is zero after any reset. Bit pre_q[2] therefore has a period of 8 counts.
- R6: ref_tick is high for one system cycle on each rising edge of xtal_clk when src_xtal is 1, and of ext_clk when src_xtal is 0.
- R7: While src_xtal and ext_clk are both 1, the prescaler and rate counter are held at zero. Counting resumes from zero once ext_clk returns low.
- R8: After system reset, or after src_xtal falls, the first high level on ext_clk clears the counters and is not counted. Later ext_clk edges count normally.
- R9: A new rate_sel value takes effect only at the next output period boundary, so the period in progress keeps its old length.
- R10: A slower reference scales every output period in proportion, with no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_xtal | input | 1 | 1 selects xtal_clk as reference, 0 selects ext_clk |
| xtal_clk | input | 1 | Crystal-path reference level |
| ext_clk | input | 1 | External clock-pulse level, also the init source |
| rate_sel | input | 4 | Rate select code |
| mux_in | input | 1 | Pass-through input for codes 0000 and 0001 |
| ref_tick | output | 1 | One-cycle pulse per active reference edge |
| pre_q | output | 3 | Divide-by-8 prescaler stages |
| baud_out | output | 1 | Serial clock output |

## Verification
The assertions check on every cycle that ref_tick comes from the selected source's rising edge and that the prescaler steps once per pulse and holds otherwise. They also check that the continuous-reset condition zeroes the counters and that the in-effect select code changes only on a period boundary. The bench alone shows the measured periods and high times for every rate code, including the three-period pattern at 1800 baud. Its scenarios also cover pass-through tracking, the one-shot init reset from the external input, and proportional scaling under a slower reference.

// File: rtl/baud_pkg.sv
package baud_pkg;

   localparam int unsigned RATE_CODES  = 16;
   localparam logic [3:0]  CODE_DITHER = 4'b1010;

   // rate in tenths of a baud; zero marks a pass-through code
   function automatic int unsigned rate_x10(input logic [3:0] code);
      case (code)
         4'd2:    return 500;
         4'd3:    return 750;
         4'd4:    return 1345;
         4'd5:    return 2000;
         4'd6:    return 6000;
         4'd7:    return 24000;
         4'd8:    return 96000;
         4'd9:    return 48000;
         4'd10:   return 18000;
         4'd11:   return 12000;
         4'd12:   return 24000;
         4'd13:   return 3000;
         4'd14:   return 1500;
         4'd15:   return 1100;
         default: return 0;
      endcase
   endfunction

   // rounded reference counts per output period
   function automatic int unsigned div_of(input logic [3:0] code,
                                          input int unsigned ref_hz,
                                          input int unsigned ovs);
      int unsigned r;
      r = rate_x10(code);
      if (r == 0) return 0;
      return (ref_hz * 10 + (ovs * r) / 2) / (ovs * r);
   endfunction

   function automatic logic is_pass(input logic [3:0] code);
      return code[3:1] == 3'b000;
   endfunction

endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic src_xtal,
   input  logic xtal_clk,
   input  logic ext_clk,
   output logic tick,
   output logic init_rst
);
   logic xtal_q, ext_q, armed;

   always_ff @(posedge clk) begin
      xtal_q <= xtal_clk;
      ext_q  <= ext_clk;
   end

   assign tick     = src_xtal ? (xtal_clk & ~xtal_q) : (ext_clk & ~ext_q);
   assign init_rst = ext_clk & (src_xtal | armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed <= 1'b1;
      else if (src_xtal) armed <= 1'b1;
      else if (ext_clk)  armed <= 1'b0;
   end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   output logic [STAGES-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (tick) q <= q + STAGES'(1);
   end
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div
   import baud_pkg::*;
#(
   parameter int unsigned REF_HZ = 2457600,
   parameter int unsigned OVS    = 16,
   parameter int          CW     = 12,
   parameter bit          DITHER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [3:0]    sel,
   input  logic          mux_in,
   output logic          baud,
   output logic [3:0]    sel_now,
   output logic          cnt_zero
);
   logic [CW-1:0] div_tab [RATE_CODES];
   logic [CW-1:0] cnt, per, half;
   logic [1:0]    ph;
   logic          extra, last, pass;

   for (genvar g = 0; g < RATE_CODES; g++) begin : g_tab
      localparam int unsigned DV = div_of(4'(g), REF_HZ, OVS);
      if (DV + 1 >= (2 ** CW)) begin : g_bad
         $error("baud_rate_div: CW too small for divisor");
      end
      assign div_tab[g] = CW'(DV);
   end

   if (DITHER) begin : g_dither
      assign extra = (sel_now == CODE_DITHER) && (ph == 2'd2);
   end else begin : g_flat
      assign extra = 1'b0;
   end

   assign per      = div_tab[sel_now] + CW'(extra);
   assign half     = per >> 1;
   assign last     = (cnt == per - CW'(1));
   assign pass     = is_pass(sel_now);
   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         sel_now <= 4'd0;
         ph      <= 2'd0;
      end else if (clr) begin
         cnt     <= '0;
         sel_now <= sel;
         ph      <= 2'd0;
      end else if (tick) begin
         if (pass || last) begin
            cnt     <= '0;
            sel_now <= sel;
            ph      <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   assign baud = pass ? mux_in : (cnt < half);
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
   parameter int unsigned REF_HZ     = 2457600,
   parameter int unsigned OVS        = 16,
   parameter int          CW         = 12,
   parameter int          PRE_STAGES = 3,
   parameter bit          DITHER     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  src_xtal,
   input  logic                  xtal_clk,
   input  logic                  ext_clk,
   input  logic [3:0]            rate_sel,
   input  logic                  mux_in,
   output logic                  ref_tick,
   output logic [PRE_STAGES-1:0] pre_q,
   output logic                  baud_out
);
   if (PRE_STAGES < 1) begin : g_bad_pre
      $error("baud_gen: PRE_STAGES must be positive");
   end

   logic       init_rst, cnt_zero;
   logic [3:0] sel_now;

   baud_src_sel u_src (
      .clk(clk), .rst_n(rst_n), .src_xtal(src_xtal), .xtal_clk(xtal_clk),
      .ext_clk(ext_clk), .tick(ref_tick), .init_rst(init_rst)
   );

   baud_prescaler #(.STAGES(PRE_STAGES)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(init_rst), .tick(ref_tick), .q(pre_q)
   );

   baud_rate_div #(.REF_HZ(REF_HZ), .OVS(OVS), .CW(CW), .DITHER(DITHER)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(init_rst), .tick(ref_tick),
      .sel(rate_sel), .mux_in(mux_in), .baud(baud_out),
      .sel_now(sel_now), .cnt_zero(cnt_zero)
   );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
   parameter int PRE_STAGES = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  src_xtal,
   input logic                  xtal_clk,
   input logic                  ext_clk,
   input logic                  ref_tick,
   input logic                  init_rst,
   input logic [PRE_STAGES-1:0] pre_q,
   input logic [3:0]            sel_now,
   input logic                  cnt_zero
);
   p_presc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_tick && !init_rst) |=> $stable(pre_q));

   p_presc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && !init_rst) |=> pre_q == $past(pre_q) + PRE_STAGES'(1));

   p_tick_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_tick |-> (src_xtal ? (xtal_clk && !$past(xtal_clk))
                             : (ext_clk && !$past(ext_clk))));

   p_cont_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_xtal && ext_clk) |=> (pre_q == '0 && cnt_zero));

   p_sel_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_now) |-> cnt_zero);
endmodule

bind baud_gen baud_gen_chk #(.PRE_STAGES(PRE_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_xtal(src_xtal), .xtal_clk(xtal_clk),
   .ext_clk(ext_clk), .ref_tick(ref_tick), .init_rst(init_rst),
   .pre_q(pre_q), .sel_now(sel_now), .cnt_zero(cnt_zero)
);

// File: tb/baud_gen_test.sv
module baud_gen_test;
   localparam int CLK_P = 10;

   logic       clk = 1'b0, rst_n = 1'b0, src_xtal = 1'b1;
   logic       xtal_clk = 1'b0, ext_clk = 1'b0, mux_in = 1'b0;
   logic [3:0] rate_sel = 4'd0;
   logic       ref_tick, baud_out;
   logic [2:0] pre_q;

   int  checks = 0, errors = 0;
   int  ref_half = 1;
   bit  xtal_on = 1'b0, done = 1'b0;

   baud_gen uut (
      .clk(clk), .rst_n(rst_n), .src_xtal(src_xtal), .xtal_clk(xtal_clk),
      .ext_clk(ext_clk), .rate_sel(rate_sel), .mux_in(mux_in),
      .ref_tick(ref_tick), .pre_q(pre_q), .baud_out(baud_out)
   );

   always #(CLK_P / 2) clk = ~clk;

   // crystal-path reference: toggles every ref_half system cycles
   initial begin
      int hc = 0;
      forever begin
         @(posedge clk); #1;
         if (xtal_on) begin
            hc++;
            if (hc >= ref_half) begin
               hc = 0;
               xtal_clk = ~xtal_clk;
            end
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic real rate_of(input int c);
      case (c)
         2: return 50.0;    3: return 75.0;    4: return 134.5;  5: return 200.0;
         6: return 600.0;   7: return 2400.0;  8: return 9600.0; 9: return 4800.0;
         10: return 1800.0; 11: return 1200.0; 12: return 2400.0;
         13: return 300.0;  14: return 150.0;  default: return 110.0;
      endcase
   endfunction

   function automatic int exp_div(input int c);
      return $rtoi(2457600.0 / (16.0 * rate_of(c)) + 0.5);
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wait_rise();
      logic prev;
      @(negedge clk);
      prev = baud_out;
      forever begin
         @(negedge clk);
         if (baud_out && !prev) break;
         prev = baud_out;
      end
   endtask

   // starts on a rising sample, returns on the next one
   task automatic meas(output int per, output int hi);
      logic prev;
      per = 1; hi = baud_out ? 1 : 0; prev = baud_out;
      forever begin
         @(negedge clk);
         if (baud_out && !prev) break;
         per++;
         if (baud_out) hi++;
         prev = baud_out;
      end
   endtask

   task automatic ext_pulse();
      step(); ext_clk = 1'b1;
      step(); ext_clk = 1'b0;
      step();
   endtask

   initial begin
      int per, hi, tk, sum;
      repeat (4) step();
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R5 pre_q after reset", pre_q, 0);
      chk("R4 baud_out follows mux_in after reset", baud_out, 0);
      chk("R6 no ref_tick without source edges", ref_tick, 0);

      // R4 pass-through
      step(); mux_in = 1'b1; @(negedge clk);
      chk("R4 code 0000 mux_in high", baud_out, 1);
      xtal_on = 1'b1;
      step(); rate_sel = 4'd1; repeat (6) step();
      mux_in = 1'b0; @(negedge clk);
      chk("R4 code 0001 mux_in low", baud_out, 0);
      step(); mux_in = 1'b1; @(negedge clk);
      chk("R4 code 0001 mux_in high", baud_out, 1);
      step(); mux_in = 1'b0;

      // R6 pulse count with period-2 reference
      tk = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (ref_tick) tk++;
      end
      chk("R6 ref_tick count over 100 cycles", tk, 50);

      // R1/R2/R3 sweep of all rate codes
      for (int c = 2; c < 16; c++) begin
         rate_sel = 4'(c);
         wait_rise();
         if (c == 10) begin
            sum = 0;
            for (int k = 0; k < 3; k++) begin
               meas(per, hi);
               sum += per;
               chk($sformatf("R3 period is 85 or 86 counts (%0d clk)", per),
                   (per == 170 || per == 172), 1);
               chk($sformatf("R3 high/low skew (high %0d clk)", hi),
                   ((per - 2 * hi) <= 2 && (2 * hi - per) <= 2), 1);
            end
            chk("R3 three periods total", sum, 512);
         end else begin
            meas(per, hi);
            chk($sformatf("R1 period code %0d", c), per, 2 * exp_div(c));
            chk($sformatf("R2 high time code %0d", c), hi, exp_div(c));
         end
      end

      // R9 select change mid-period
      rate_sel = 4'd8;
      wait_rise();
      meas(per, hi);
      rate_sel = 4'd9;
      meas(per, hi);
      chk("R9 period in progress keeps old length", per, 32);
      meas(per, hi);
      chk("R9 new code after boundary", per, 64);

      // R10 slower reference
      ref_half = 2;
      rate_sel = 4'd8;
      wait_rise();
      wait_rise();
      meas(per, hi);
      chk("R10 9600 period at half reference", per, 64);
      chk("R10 high time at half reference", hi, 32);
      ref_half = 1;
      repeat (8) step();

      // R7 continuous reset
      step(); ext_clk = 1'b1;
      repeat (10) @(negedge clk);
      chk("R7 pre_q held at zero", pre_q, 0);
      chk("R7 rate counter held at period start", baud_out, 1);
      step(); ext_clk = 1'b0;
      tk = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ref_tick) tk++;
      end
      @(negedge clk);
      chk("R7 counting resumes from zero", pre_q, tk % 8);
      chk("R5 count matches pulses", (tk > 0), 1);

      // R5 prescaler top stage period
      begin
         logic prev;
         int p2;
         @(negedge clk); prev = pre_q[2];
         forever begin @(negedge clk); if (pre_q[2] && !prev) break; prev = pre_q[2]; end
         p2 = 0; prev = 1'b1;
         forever begin
            @(negedge clk); p2++;
            if (pre_q[2] && !prev) break;
            prev = pre_q[2];
         end
         chk("R5 pre_q[2] period in clk", p2, 16);
      end

      // R8 init reset from external source
      step(); src_xtal = 1'b0; xtal_on = 1'b0;
      repeat (3) step();
      @(negedge clk);
      chk("R8 pre_q nonzero before init", (pre_q != 0), 1);
      ext_pulse();
      @(negedge clk);
      chk("R8 first ext high clears and is not counted", pre_q, 0);
      ext_pulse(); ext_pulse(); ext_pulse();
      @(negedge clk);
      chk("R8 later ext edges count", pre_q, 3);
      tk = 0;
      step(); ext_clk = 1'b1; @(negedge clk); if (ref_tick) tk++;
      step(); ext_clk = 1'b0;
      chk("R6 ref_tick from ext_clk when src_xtal low", tk, 1);
      @(negedge clk);
      chk("R8 count after fourth edge", pre_q, 4);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule